// File: doc/BRIEF.md
# Dual-Context Register Backup Controller

This controller lets two tasks share one bank of flip-flops by parking each task's register state in its own retention layer. Layer 0 belongs to context 0 and layer 1 to context 1. When a switch to the other context is requested, the live register contents are first written into the active context's layer. The layer of the target context is then read back into the registers. Each layer has its own backup strobe and its own restore strobe, and every strobe is held for a fixed number of cycles set by a parameter.

The same save path is used before power gating. On a sleep request the active context is saved, isolation is raised, and only after that is the power-gate enable driven. On a wake request the sequence runs in reverse: the gate enable drops, isolation is released, and the active layer is restored. Only then does the block report ready again.

The retention storage is modelled behaviourally inside the block. Each entry into the gated state also advances a counter. When that counter reaches a programmable threshold, the block raises a refresh request for the retention storage.

Top module: `ctx_retention_ctrl`

## Requirements
- R1: After reset the current context is 0 and ready is high. Both layers are invalid, and every strobe, powerGateEn, isolateEn, restoreErr, refreshReq and liveOut are 0.
- R2: A switch to the other context proceeds in three steps. First bkStrobe[cur] is held high for BK_CYC cycles. Then reStrobe[target] is held high for RE_CYC cycles. Finally liveOut takes the target layer's saved data, liveLoad pulses, curCtx becomes the target and swAck pulses for one cycle. Bit n of each strobe vector addresses layer n.
- R3: A switch whose target equals curCtx pulses swAck without any backup or restore strobe and leaves liveOut unchanged.
- R4: If the target layer has never been saved, the switch still performs its backup, but it drives no restore strobe. In that case restoreErr is set, liveOut is unchanged, curCtx still becomes the target and swAck pulses. restoreErr clears when the next request starts being serviced.
- R5: A sleep request saves the current context through bkStrobe[cur] for BK_CYC cycles. isolateEn then rises at least one cycle before powerGateEn, and powerGateEn rises only once the current layer holds a completed backup.
- R6: On wake, powerGateEn falls at least one cycle before isolateEn. The current layer is then restored through reStrobe[cur] for RE_CYC cycles. ready rises only after that, with liveOut equal to the data saved at sleep.
- R7: Each layer keeps its data across gating and across any activity of the other context.
- R8: A request that arrives while an operation is in progress is held and serviced after that operation completes. In the idle state a pending switch is taken before a pending sleep.
- R9: A wake request that arrives while the block is idle is ignored, so a later sleep stays gated until a new wake arrives.
- R10: Every entry into the gated state counts one cycle. When the count reaches refreshThresh (threshold 1 or more), refreshReq is set and the count restarts from zero. refreshAck clears refreshReq.
- R11: At most one backup or restore strobe is high at any time, and none is high while ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| swReq | input | 1 | Context switch request pulse |
| swTarget | input | 1 | Context selected by the switch request |
| sleepReq | input | 1 | Save-and-gate request pulse |
| wakeReq | input | 1 | Ungate-and-restore request pulse |
| liveIn | input | REG_W | Current contents of the register bank |
| refreshThresh | input | CNT_W | Number of gated cycles per refresh request |
| refreshAck | input | 1 | Clears the refresh request |
| liveOut | output | REG_W | Data restored into the register bank |
| liveLoad | output | 1 | One-cycle pulse when liveOut is freshly loaded |
| bkStrobe | output | 2 | Backup strobe per layer |
| reStrobe | output | 2 | Restore strobe per layer |
| powerGateEn | output | 1 | Power switch enable |
| isolateEn | output | 1 | Output isolation enable |
| curCtx | output | 1 | Active context |
| ready | output | 1 | Idle and able to accept new work |
| swAck | output | 1 | One-cycle pulse when a switch finishes |
| restoreErr | output | 1 | Target layer was empty on the last switch |
| refreshReq | output | 1 | Retention refresh needed |

## Verification
The bench builds the block with REG_W = 8, BK_CYC = 3 and RE_CYC = 4. Because the two window lengths differ, a backup strobe length can never be taken for a restore strobe length. It drives refreshThresh = 3, so the refresh request appears on the third sleep of the run and its clearing by refreshAck can be observed. With byte-wide data patterns, each layer's contents can be traced through a chain of switches and sleeps. The chain starts from the empty-layer error case.

// File: rtl/ctx_ret_pkg.sv
package ctx_ret_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAVE,
    ST_LOAD,
    ST_ISO,
    ST_GATED,
    ST_UNGATE
  } ctlState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic save;      // write liveIn into layer 'layer'
    logic restore;   // copy layer 'layer' to liveOut
    logic layer;     // selected layer
    logic gateTick;  // one pulse per entry into gating
  } dpCmd_t;

endpackage

// File: rtl/ctx_ret_dp.sv
module ctx_ret_dp
  import ctx_ret_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic [REG_W-1:0] liveIn,
  input  logic [CNT_W-1:0] refreshThresh,
  input  logic             refreshAck,
  output logic [REG_W-1:0] liveOut,
  output logic             liveLoad,
  output logic [1:0]       validBits,
  output logic             refreshReq
);

  localparam int LAYERS = 2;

  logic [REG_W-1:0] layerData [LAYERS];
  logic [CNT_W-1:0] gateCount;
  logic [CNT_W-1:0] gateNext;

  // Behavioural retention layers, one per context
  for (genvar l = 0; l < LAYERS; l++) begin : g_layer
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        layerData[l] <= '0;
        validBits[l] <= 1'b0;
      end else if (cmd.save && (cmd.layer == l[0])) begin
        layerData[l] <= liveIn;
        validBits[l] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveOut  <= '0;
      liveLoad <= 1'b0;
    end else begin
      liveLoad <= cmd.restore;
      if (cmd.restore) liveOut <= layerData[cmd.layer];
    end
  end

  assign gateNext = gateCount + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateCount  <= '0;
      refreshReq <= 1'b0;
    end else begin
      if (refreshAck) refreshReq <= 1'b0;
      if (cmd.gateTick) begin
        if (gateNext >= refreshThresh) begin
          gateCount  <= '0;
          refreshReq <= 1'b1;
        end else begin
          gateCount <= gateNext;
        end
      end
    end
  end

  // A layer becomes valid only by a save
  AST_VALID_BY_SAVE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(validBits[0]) |-> $past(cmd.save) && !$past(cmd.layer)); // R7

  AST_LOAD_ONLY_VALID: assert property (@(posedge clk) disable iff (!rstN)
    cmd.restore |-> validBits[cmd.layer]); // R4

endmodule

// File: rtl/ctx_ret_ctrl.sv
module ctx_ret_ctrl
  import ctx_ret_pkg::*;
#(
  parameter int BK_CYC = 8,
  parameter int RE_CYC = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       swReq,
  input  logic       swTarget,
  input  logic       sleepReq,
  input  logic       wakeReq,
  input  logic [1:0] validBits,
  output dpCmd_t     cmd,
  output logic [1:0] bkStrobe,
  output logic [1:0] reStrobe,
  output logic       powerGateEn,
  output logic       isolateEn,
  output logic       curCtx,
  output logic       ready,
  output logic       swAck,
  output logic       restoreErr
);

  localparam int MAXC = (BK_CYC > RE_CYC) ? BK_CYC : RE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] BK_LAST = CW'(BK_CYC - 1);
  localparam logic [CW-1:0] RE_LAST = CW'(RE_CYC - 1);

  ctlState_t     state;
  logic [CW-1:0] winCnt;
  logic          tgtCtx;
  logic          sleepOp;
  logic          pendSw, pendTgt, pendSleep, pendWake;
  logic          takeSw, takeSleep, takeWake;

  assign takeSw    = (state == ST_IDLE) && pendSw;
  assign takeSleep = (state == ST_IDLE) && !pendSw && pendSleep;
  assign takeWake  = (state == ST_GATED) && pendWake;

  // Pending request latches; a fresh pulse wins over consumption
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendSw    <= 1'b0;
      pendTgt   <= 1'b0;
      pendSleep <= 1'b0;
      pendWake  <= 1'b0;
    end else begin
      if (takeSw) pendSw <= 1'b0;
      if (swReq) begin
        pendSw  <= 1'b1;
        pendTgt <= swTarget;
      end
      if (takeSleep) pendSleep <= 1'b0;
      if (sleepReq) pendSleep <= 1'b1;
      if (takeWake) pendWake <= 1'b0;
      if (wakeReq && state != ST_IDLE && sleepOp) pendWake <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      winCnt     <= '0;
      curCtx     <= 1'b0;
      tgtCtx     <= 1'b0;
      sleepOp    <= 1'b0;
      swAck      <= 1'b0;
      restoreErr <= 1'b0;
    end else begin
      swAck <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (takeSw) begin
            restoreErr <= 1'b0;
            sleepOp    <= 1'b0;
            if (pendTgt == curCtx) begin
              swAck <= 1'b1;
            end else begin
              tgtCtx <= pendTgt;
              winCnt <= BK_LAST;
              state  <= ST_SAVE;
            end
          end else if (takeSleep) begin
            restoreErr <= 1'b0;
            sleepOp    <= 1'b1;
            winCnt     <= BK_LAST;
            state      <= ST_SAVE;
          end
        end
        ST_SAVE: begin
          if (winCnt != '0) begin
            winCnt <= winCnt - 1'b1;
          end else if (sleepOp) begin
            state <= ST_ISO;
          end else if (validBits[tgtCtx]) begin
            winCnt <= RE_LAST;
            state  <= ST_LOAD;
          end else begin
            restoreErr <= 1'b1;
            curCtx     <= tgtCtx;
            swAck      <= 1'b1;
            state      <= ST_IDLE;
          end
        end
        ST_LOAD: begin
          if (winCnt != '0) begin
            winCnt <= winCnt - 1'b1;
          end else begin
            curCtx <= tgtCtx;
            swAck  <= !sleepOp;
            state  <= ST_IDLE;
          end
        end
        ST_ISO:   state <= ST_GATED;
        ST_GATED: if (takeWake) state <= ST_UNGATE;
        ST_UNGATE: begin
          tgtCtx <= curCtx;
          winCnt <= RE_LAST;
          state  <= ST_LOAD;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd.save     = (state == ST_SAVE) && (winCnt == '0);
    cmd.restore  = (state == ST_LOAD) && (winCnt == '0);
    cmd.layer    = (state == ST_SAVE) ? curCtx : tgtCtx;
    cmd.gateTick = (state == ST_ISO);
  end

  assign bkStrobe    = (state == ST_SAVE) ? (curCtx ? 2'b10 : 2'b01) : 2'b00;
  assign reStrobe    = (state == ST_LOAD) ? (tgtCtx ? 2'b10 : 2'b01) : 2'b00;
  assign isolateEn   = (state == ST_ISO) || (state == ST_GATED) || (state == ST_UNGATE);
  assign powerGateEn = (state == ST_GATED);
  assign ready       = (state == ST_IDLE);

  AST_GATE_UNDER_ISO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(powerGateEn) |-> $past(isolateEn)); // R5

  AST_ISO_AFTER_GATE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(isolateEn) |-> !$past(powerGateEn)); // R6

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({bkStrobe, reStrobe})); // R11

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (bkStrobe == 2'b00) && (reStrobe == 2'b00) && !powerGateEn); // R11

  AST_CTX_STABLE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    powerGateEn |-> $stable(curCtx)); // R7

endmodule

// File: rtl/ctx_retention_ctrl.sv
module ctx_retention_ctrl
  import ctx_ret_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int BK_CYC = 8,
  parameter int RE_CYC = 9,
  parameter int CNT_W  = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             swReq,
  input  logic             swTarget,
  input  logic             sleepReq,
  input  logic             wakeReq,
  input  logic [REG_W-1:0] liveIn,
  input  logic [CNT_W-1:0] refreshThresh,
  input  logic             refreshAck,
  output logic [REG_W-1:0] liveOut,
  output logic             liveLoad,
  output logic [1:0]       bkStrobe,
  output logic [1:0]       reStrobe,
  output logic             powerGateEn,
  output logic             isolateEn,
  output logic             curCtx,
  output logic             ready,
  output logic             swAck,
  output logic             restoreErr,
  output logic             refreshReq
);

  dpCmd_t     cmd;
  logic [1:0] validBits;

  ctx_ret_ctrl #(.BK_CYC(BK_CYC), .RE_CYC(RE_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .swReq(swReq), .swTarget(swTarget),
    .sleepReq(sleepReq), .wakeReq(wakeReq), .validBits(validBits),
    .cmd(cmd), .bkStrobe(bkStrobe), .reStrobe(reStrobe),
    .powerGateEn(powerGateEn), .isolateEn(isolateEn), .curCtx(curCtx),
    .ready(ready), .swAck(swAck), .restoreErr(restoreErr)
  );

  ctx_ret_dp #(.REG_W(REG_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .liveIn(liveIn),
    .refreshThresh(refreshThresh), .refreshAck(refreshAck),
    .liveOut(liveOut), .liveLoad(liveLoad), .validBits(validBits),
    .refreshReq(refreshReq)
  );

  AST_GATE_AFTER_SAVE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(powerGateEn) |-> validBits[curCtx]); // R5

  AST_REFRESH_ON_GATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refreshReq) |-> powerGateEn); // R10

  AST_LOAD_NO_ERR: assert property (@(posedge clk) disable iff (!rstN)
    liveLoad |-> !restoreErr); // R4

endmodule

// File: tb/ctx_retention_ctrl_test.sv
module ctx_retention_ctrl_test;

  localparam int REG_W = 8;
  localparam int BKC   = 3;
  localparam int REC   = 4;
  localparam int CNT_W = 18;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swReq = 0, swTarget = 0, sleepReq = 0, wakeReq = 0, refreshAck = 0;
  logic [REG_W-1:0] liveIn = '0;
  logic [CNT_W-1:0] refreshThresh = CNT_W'(3);
  logic [REG_W-1:0] liveOut;
  logic liveLoad, powerGateEn, isolateEn, curCtx, ready, swAck, restoreErr, refreshReq;
  logic [1:0] bkStrobe, reStrobe;

  int checks = 0;
  int fails  = 0;
  int nB0, nB1, nR0, nR1;
  int orderBad = 0;
  logic prevIso = 0, prevPg = 0;
  logic done = 0;

  always #10 clk = ~clk;

  ctx_retention_ctrl #(.REG_W(REG_W), .BK_CYC(BKC), .RE_CYC(REC), .CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .swReq(swReq), .swTarget(swTarget),
    .sleepReq(sleepReq), .wakeReq(wakeReq), .liveIn(liveIn),
    .refreshThresh(refreshThresh), .refreshAck(refreshAck),
    .liveOut(liveOut), .liveLoad(liveLoad), .bkStrobe(bkStrobe),
    .reStrobe(reStrobe), .powerGateEn(powerGateEn), .isolateEn(isolateEn),
    .curCtx(curCtx), .ready(ready), .swAck(swAck),
    .restoreErr(restoreErr), .refreshReq(refreshReq)
  );

  // Strobe cycle counters and gating order monitor
  always @(negedge clk) begin
    if (bkStrobe[0]) nB0++;
    if (bkStrobe[1]) nB1++;
    if (reStrobe[0]) nR0++;
    if (reStrobe[1]) nR1++;
    if (powerGateEn && !prevPg && !prevIso) orderBad++;   // R5
    if (!isolateEn && prevIso && prevPg) orderBad++;      // R6
    prevIso = isolateEn;
    prevPg  = powerGateEn;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clrCounts();
    nB0 = 0; nB1 = 0; nR0 = 0; nR1 = 0;
  endtask

  task automatic doSwitch(input logic tgt);
    @(negedge clk); swTarget = tgt; swReq = 1;
    @(negedge clk); swReq = 0;
    for (int i = 0; i < 100; i++) begin
      if (swAck) break;
      @(negedge clk);
    end
  endtask

  task automatic waitGated();
    for (int i = 0; i < 100; i++) begin
      if (powerGateEn) break;
      @(negedge clk);
    end
  endtask

  task automatic doWake();
    @(negedge clk); wakeReq = 1;
    @(negedge clk); wakeReq = 0;
    for (int i = 0; i < 100; i++) begin
      if (ready) break;
      @(negedge clk);
    end
  endtask

  task automatic doSleep();
    @(negedge clk); sleepReq = 1;
    @(negedge clk); sleepReq = 0;
    waitGated();
    repeat (3) @(negedge clk);
    doWake();
  endtask

  typedef struct packed {
    logic       isSleep;
    logic       tgt;
    logic [7:0] data;
    logic       eCtx;
    logic [7:0] eOut;
    logic       eErr;
    logic [3:0] eB0, eB1, eR0, eR1;
  } vec_t;

  // Chain of switches and sleeps; BK=3, RE=4 cycles
  localparam vec_t VECS [7] = '{
    '{1'b0, 1'b1, 8'hA1, 1'b1, 8'h00, 1'b1, 4'd3, 4'd0, 4'd0, 4'd0}, // R4 empty layer 1
    '{1'b0, 1'b1, 8'h5A, 1'b1, 8'h00, 1'b0, 4'd0, 4'd0, 4'd0, 4'd0}, // R3 same target
    '{1'b0, 1'b0, 8'hB2, 1'b0, 8'hA1, 1'b0, 4'd0, 4'd3, 4'd4, 4'd0}, // R2
    '{1'b1, 1'b0, 8'hC3, 1'b0, 8'hC3, 1'b0, 4'd3, 4'd0, 4'd4, 4'd0}, // R5 R6
    '{1'b0, 1'b1, 8'hD4, 1'b1, 8'hB2, 1'b0, 4'd3, 4'd0, 4'd0, 4'd4}, // R2 R7
    '{1'b1, 1'b0, 8'hE5, 1'b1, 8'hE5, 1'b0, 4'd0, 4'd3, 4'd0, 4'd4}, // R5 R6
    '{1'b0, 1'b0, 8'hF6, 1'b0, 8'hD4, 1'b0, 4'd0, 4'd3, 4'd4, 4'd0}  // R7 kept across gating
  };

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 curCtx", curCtx, 0);
    chk("R1 ready", ready, 1);
    chk("R1 strobes", {bkStrobe, reStrobe}, 0);
    chk("R1 gate/iso", {powerGateEn, isolateEn}, 0);
    chk("R1 err/refresh", {restoreErr, refreshReq}, 0);
    chk("R1 liveOut", liveOut, 0);

    foreach (VECS[k]) begin
      clrCounts();
      liveIn = VECS[k].data;
      if (VECS[k].isSleep) doSleep();
      else doSwitch(VECS[k].tgt);
      @(negedge clk);
      chk($sformatf("R2 vec%0d curCtx", k), curCtx, VECS[k].eCtx);
      chk($sformatf("R7 vec%0d liveOut", k), liveOut, VECS[k].eOut);
      chk($sformatf("R4 vec%0d restoreErr", k), restoreErr, VECS[k].eErr);
      chk($sformatf("R11 vec%0d bk0 cycles", k), nB0, VECS[k].eB0);
      chk($sformatf("R11 vec%0d bk1 cycles", k), nB1, VECS[k].eB1);
      chk($sformatf("R6 vec%0d re0 cycles", k), nR0, VECS[k].eR0);
      chk($sformatf("R6 vec%0d re1 cycles", k), nR1, VECS[k].eR1);
    end
    chk("R10 no refresh after two sleeps", refreshReq, 0);
    chk("R5 R6 gating order", orderBad, 0);

    // R9 wake while idle is ignored
    @(negedge clk); wakeReq = 1;
    @(negedge clk); wakeReq = 0;
    liveIn = 8'h17;
    @(negedge clk); sleepReq = 1;
    @(negedge clk); sleepReq = 0;
    // R8 switch arriving during the sleep save is held
    swTarget = 1; swReq = 1;
    @(negedge clk); swReq = 0;
    waitGated();
    repeat (6) @(negedge clk);
    chk("R9 still gated", powerGateEn, 1);
    chk("R8 held switch not serviced yet", curCtx, 0);
    chk("R10 refresh on third gating", refreshReq, 1);
    @(negedge clk); refreshAck = 1;
    @(negedge clk); refreshAck = 0;
    chk("R10 ack clears refresh", refreshReq, 0);
    doWake();
    chk("R6 restored at wake", liveOut, 8'h17);
    clrCounts();
    for (int i = 0; i < 100; i++) begin
      if (swAck) break;
      @(negedge clk);
    end
    @(negedge clk);
    chk("R8 held switch done", curCtx, 1);
    chk("R8 held switch data", liveOut, 8'hF6);
    chk("R8 held switch backup layer0", nB0, BKC);
    chk("R5 R6 gating order final", orderBad, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule